// File: doc/BRIEF.md
# Thirty-Two Pin I/O Port Controller with Change Interrupts

This block gives software control over a bank of general-purpose pins through six 32-bit registers on a simple single-cycle bus. Each pin is either an output driven from a stored level or an input whose level is sampled into that same storage. Outputs can be push-pull or open-drain. Input pins pass through a two-flop synchronizer, and a level change on an input can raise a sticky per-pin event. The block ORs all masked events into a single interrupt line.

Pin numbering runs from the most significant end: pin n lives in register bit 31−n. A per-pin mode bit chooses whether any level change or only a high-to-low change raises an event. Software clears events by writing ones to them. Reads are combinational in the cycle of the request. Writes take effect at the next rising clock edge.

Top module: `pinbank_top`

## Requirements
- R1: Register offsets are 0x000 direction, 0x004 open-drain, 0x008 level (data), 0x00C event, 0x010 event mask and 0x014 event mode. Any other address, including an unaligned one, reads as zero and ignores writes.
- R2: Pin n corresponds to register bit 31−n in every register, so pin 0 is bit 31 and pin 31 is bit 0.
- R3: `req_size` gives the access width in bytes. Only the value 4 is honoured. A read of any other size returns zero, and a write of any other size changes no register.
- R4: A direction bit of 1 makes the pin an output. A full write to the level register changes only those level bits whose direction bit is 1. A pin whose direction bit is 0 has its output enable low.
- R5: While its direction bit is 0, a pin's level bit follows the pin through a two-flop synchronizer, so a change is visible in the register after the third rising edge. While its direction bit is 1, the level bit changes only through a level-register write.
- R6: For an input pin whose mode bit is 0, any synchronized level change sets its event bit. When the mode bit is 1, only a 1-to-0 change sets the bit. Output pins raise no events.
- R7: Writing a 1 to an event bit clears it. Writing a 0 leaves it unchanged.
- R8: `irq` is high exactly when the bitwise AND of the event and mask registers is non-zero. It follows every register update in the same cycle.
- R9: Reset clears all six registers, so every pin starts as an input with no events, interrupts masked and all output enables low.
- R10: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R11: For an output pin with its open-drain bit set, a level of 1 releases the pin (enable low) and a level of 0 drives it low (enable high, value 0). Without the open-drain bit, the pin is driven with enable high to its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte address within the register window |
| req_size | input | 3 | Access width in bytes |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid in the request cycle |
| pin_in | input | 32 | Pin levels, index = pin number |
| pin_out | output | 32 | Driven value per pin |
| pin_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined masked event interrupt |

## Verification
The hardest case to reach is a synchronized input edge landing in the exact cycle that a clear write targets the same event bit. The two-flop path means the pin has to toggle two clock edges before the write is sampled. The bench sets the pin at a falling edge, waits one more falling edge, and then issues the clear so that both act at the same rising edge. Random steps mix pin toggles with register writes, including narrow and unmapped ones. This exercises events on pins whose direction or mode has just changed.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int PIN_COUNT  = 32;
    localparam int ADDR_WIDTH = 12;
    localparam int SIZE_WIDTH = 3;
    localparam int FULL_BYTES = 4;
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_WIDTH-1:0] OFS_PINDIR = 12'h000;
    localparam logic [ADDR_WIDTH-1:0] OFS_ODRAIN = 12'h004;
    localparam logic [ADDR_WIDTH-1:0] OFS_LEVEL  = 12'h008;
    localparam logic [ADDR_WIDTH-1:0] OFS_EVENT  = 12'h00C;
    localparam logic [ADDR_WIDTH-1:0] OFS_EVMASK = 12'h010;
    localparam logic [ADDR_WIDTH-1:0] OFS_EVMODE = 12'h014;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PINDIR,
        SEL_ODRAIN,
        SEL_LEVEL,
        SEL_EVENT,
        SEL_EVMASK,
        SEL_EVMODE
    } reg_sel_e;

    typedef struct packed {
        logic                  valid;
        logic                  write;
        logic [ADDR_WIDTH-1:0] addr;
        logic [SIZE_WIDTH-1:0] size;
    } bus_ctl_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_WIDTH-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_PINDIR: s = SEL_PINDIR;
            OFS_ODRAIN: s = SEL_ODRAIN;
            OFS_LEVEL:  s = SEL_LEVEL;
            OFS_EVENT:  s = SEL_EVENT;
            OFS_EVMASK: s = SEL_EVMASK;
            OFS_EVMODE: s = SEL_EVMODE;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_full(input logic [SIZE_WIDTH-1:0] sz);
        return sz == SIZE_WIDTH'(FULL_BYTES);
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int N      = pinbank_pkg::PIN_COUNT,
    parameter int STAGES = pinbank_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] sync_bits,
    output logic [N-1:0] prev_bits
);

    for (genvar n = 0; n < N; n++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], pin_in[n]};
        end
        // pin n lands on register bit N-1-n
        assign sync_bits[N-1-n] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_bits <= '0;
        else     prev_bits <= sync_bits;
    end

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
#(
    parameter int N = PIN_COUNT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bus_ctl_t              ctl,
    input  logic [N-1:0]          wdata,
    input  logic [N-1:0]          sync_bits,
    input  logic [N-1:0]          evt_q,
    output logic [N-1:0]          rd_data,
    output logic [N-1:0]          dir_q,
    output logic [N-1:0]          odr_q,
    output logic [N-1:0]          lvl_q,
    output logic [N-1:0]          msk_q,
    output logic [N-1:0]          mod_q,
    output logic [N-1:0]          evt_clr
);

    reg_sel_e     sel;
    logic         wr_ok;
    logic         rd_ok;
    logic [N-1:0] lvl_next;

    assign sel   = decode_addr(ctl.addr);
    assign wr_ok = ctl.valid &&  ctl.write && is_full(ctl.size);
    assign rd_ok = ctl.valid && !ctl.write && is_full(ctl.size);

    assign evt_clr = (wr_ok && sel == SEL_EVENT) ? wdata : '0;

    always_comb begin
        if (wr_ok && sel == SEL_LEVEL) lvl_next = wdata & dir_q;
        else                           lvl_next = lvl_q & dir_q;
        lvl_next = lvl_next | (sync_bits & ~dir_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            odr_q <= '0;
            lvl_q <= '0;
            msk_q <= '0;
            mod_q <= '0;
        end else begin
            lvl_q <= lvl_next;
            if (wr_ok) begin
                case (sel)
                    SEL_PINDIR: dir_q <= wdata;
                    SEL_ODRAIN: odr_q <= wdata;
                    SEL_EVMASK: msk_q <= wdata;
                    SEL_EVMODE: mod_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_ok) begin
            case (sel)
                SEL_PINDIR: rd_data = dir_q;
                SEL_ODRAIN: rd_data = odr_q;
                SEL_LEVEL:  rd_data = lvl_q;
                SEL_EVENT:  rd_data = evt_q;
                SEL_EVMASK: rd_data = msk_q;
                SEL_EVMODE: rd_data = mod_q;
                default:    rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/pinbank_events.sv
module pinbank_events #(
    parameter int N = pinbank_pkg::PIN_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sync_bits,
    input  logic [N-1:0] prev_bits,
    input  logic [N-1:0] dir_q,
    input  logic [N-1:0] mod_q,
    input  logic [N-1:0] evt_clr,
    output logic [N-1:0] hit,
    output logic [N-1:0] evt_q
);

    logic [N-1:0] changed;
    logic [N-1:0] falling;

    assign changed = sync_bits ^ prev_bits;
    assign falling = prev_bits & ~sync_bits;
    assign hit     = ~dir_q & ((~mod_q & changed) | (mod_q & falling));

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= (evt_q & ~evt_clr) | hit;
    end

endmodule

// File: rtl/pinbank_drive.sv
module pinbank_drive #(
    parameter int N = pinbank_pkg::PIN_COUNT
) (
    input  logic [N-1:0] dir_q,
    input  logic [N-1:0] odr_q,
    input  logic [N-1:0] lvl_q,
    output logic [N-1:0] pin_out,
    output logic [N-1:0] pin_oe
);

    for (genvar n = 0; n < N; n++) begin : g_pad
        localparam int B = N - 1 - n;
        always_comb begin
            if (!dir_q[B]) begin
                pin_oe[n]  = 1'b0;
                pin_out[n] = 1'b0;
            end else if (odr_q[B]) begin
                pin_oe[n]  = ~lvl_q[B];
                pin_out[n] = 1'b0;
            end else begin
                pin_oe[n]  = 1'b1;
                pin_out[n] = lvl_q[B];
            end
        end
    end

endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
    import pinbank_pkg::*;
#(
    parameter int N  = PIN_COUNT,
    parameter int AW = ADDR_WIDTH,
    parameter int SW = SIZE_WIDTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [SW-1:0] req_size,
    input  logic [N-1:0]  req_wdata,
    output logic [N-1:0]  rd_data,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  pin_oe,
    output logic          irq
);

    bus_ctl_t     ctl;
    logic [N-1:0] sync_bits;
    logic [N-1:0] prev_bits;
    logic [N-1:0] dir_q;
    logic [N-1:0] odr_q;
    logic [N-1:0] lvl_q;
    logic [N-1:0] msk_q;
    logic [N-1:0] mod_q;
    logic [N-1:0] evt_q;
    logic [N-1:0] evt_clr;
    logic [N-1:0] hit;

    assign ctl.valid = req_valid;
    assign ctl.write = req_write;
    assign ctl.addr  = req_addr;
    assign ctl.size  = req_size;

    pinbank_sync #(.N(N), .STAGES(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .sync_bits (sync_bits),
        .prev_bits (prev_bits)
    );

    pinbank_regs #(.N(N)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .wdata     (req_wdata),
        .sync_bits (sync_bits),
        .evt_q     (evt_q),
        .rd_data   (rd_data),
        .dir_q     (dir_q),
        .odr_q     (odr_q),
        .lvl_q     (lvl_q),
        .msk_q     (msk_q),
        .mod_q     (mod_q),
        .evt_clr   (evt_clr)
    );

    pinbank_events #(.N(N)) u_events (
        .clk       (clk),
        .rst       (rst),
        .sync_bits (sync_bits),
        .prev_bits (prev_bits),
        .dir_q     (dir_q),
        .mod_q     (mod_q),
        .evt_clr   (evt_clr),
        .hit       (hit),
        .evt_q     (evt_q)
    );

    pinbank_drive #(.N(N)) u_drive (
        .dir_q   (dir_q),
        .odr_q   (odr_q),
        .lvl_q   (lvl_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    assign irq = |(evt_q & msk_q);

endmodule

// File: rtl/pinbank_checker.sv
module pinbank_checker #(
    parameter int N  = 32,
    parameter int AW = 12,
    parameter int SW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic [SW-1:0] req_size,
    input logic [N-1:0]  pin_oe,
    input logic          irq,
    input logic [N-1:0]  dir_q,
    input logic [N-1:0]  odr_q,
    input logic [N-1:0]  lvl_q,
    input logic [N-1:0]  msk_q,
    input logic [N-1:0]  mod_q,
    input logic [N-1:0]  evt_q,
    input logic [N-1:0]  evt_clr,
    input logic [N-1:0]  hit
);

    logic [N-1:0] oe_reg;
    logic         narrow_wr;
    logic         level_wr;

    always_comb begin
        for (int n = 0; n < N; n++) oe_reg[N-1-n] = pin_oe[n];
    end

    assign narrow_wr = req_valid && req_write && (req_size != SW'(4));
    assign level_wr  = req_valid && req_write && (req_size == SW'(4)) &&
                       (req_addr == AW'(8));

    p_narrow_wr_r3: assert property (@(posedge clk) disable iff (rst)
        narrow_wr |=> ($stable(dir_q) && $stable(odr_q) && $stable(msk_q) && $stable(mod_q)));

    p_oe_output_only_r4: assert property (@(posedge clk) disable iff (rst)
        (oe_reg & ~dir_q) == '0);

    p_output_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !level_wr |=> (((lvl_q ^ $past(lvl_q)) & $past(dir_q)) == '0));

    p_event_source_r6: assert property (@(posedge clk) disable iff (rst)
        (evt_q & ~$past(evt_q) & ~$past(hit)) == '0);

    p_mask_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (msk_q == '0) |-> !irq);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (dir_q == '0 && evt_q == '0 && msk_q == '0 && odr_q == '0 && mod_q == '0));

    p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        ((hit & evt_clr) != '0) |=> ((evt_q & $past(hit & evt_clr)) == $past(hit & evt_clr)));

    p_odrain_release_r11: assert property (@(posedge clk) disable iff (rst)
        (oe_reg & dir_q & odr_q & lvl_q) == '0);

endmodule

bind pinbank_top pinbank_checker #(.N(N), .AW(AW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .dir_q     (dir_q),
    .odr_q     (odr_q),
    .lvl_q     (lvl_q),
    .msk_q     (msk_q),
    .mod_q     (mod_q),
    .evt_q     (evt_q),
    .evt_clr   (evt_clr),
    .hit       (hit)
);

// File: tb/test_pinbank_top.sv
`timescale 1ns/1ps
module test_pinbank_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [31:0] pins = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [31:0] m_dir = '0, m_odr = '0, m_lvl = '0, m_evt = '0, m_msk = '0, m_mod = '0;

    always #10 clk = ~clk;

    pinbank_top i_pinbank_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_data(rd_data), .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq(irq)
    );

    function automatic logic [31:0] to_reg(input logic [31:0] p);
        logic [31:0] r;
        for (int n = 0; n < 32; n++) r[31-n] = p[n];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic brd(input logic [11:0] a, input logic [2:0] sz, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        #1 d = rd_data;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // model: full write to register index i
    task automatic m_write(input int i, input logic [31:0] w);
        case (i)
            0: m_dir = w;
            1: m_odr = w;
            2: m_lvl = (m_lvl & ~m_dir) | (w & m_dir);
            3: m_evt = m_evt & ~w;
            4: m_msk = w;
            default: m_mod = w;
        endcase
    endtask

    // model: pin change, then input bits follow pins
    task automatic m_pins(input logic [31:0] nw);
        for (int n = 0; n < 32; n++) begin
            int b = 31 - n;
            if (!m_dir[b] && (pins[n] != nw[n]))
                if (!m_mod[b] || (pins[n] && !nw[n])) m_evt[b] = 1'b1;
        end
    endtask

    task automatic set_pins(input logic [31:0] nw);
        m_pins(nw);
        @(negedge clk);
        pins = nw;
        idle(3);
    endtask

    task automatic settle_model();
        m_lvl = (m_lvl & m_dir) | (to_reg(pins) & ~m_dir);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        logic [31:0] eo, ee;
        brd(12'h000, 3'd4, d); chk({tag, " dir R1"}, d, m_dir);
        brd(12'h004, 3'd4, d); chk({tag, " odr R1"}, d, m_odr);
        brd(12'h008, 3'd4, d); chk({tag, " level R5"}, d, m_lvl);
        brd(12'h00C, 3'd4, d); chk({tag, " event R6"}, d, m_evt);
        brd(12'h010, 3'd4, d); chk({tag, " mask R1"}, d, m_msk);
        brd(12'h014, 3'd4, d); chk({tag, " mode R1"}, d, m_mod);
        chk({tag, " irq R8"}, {31'd0, irq}, {31'd0, |(m_evt & m_msk)});
        for (int n = 0; n < 32; n++) begin
            int b = 31 - n;
            eo[n] = m_dir[b] ? (m_odr[b] ? ~m_lvl[b] : 1'b1) : 1'b0;
            ee[n] = (m_dir[b] && !m_odr[b]) ? m_lvl[b] : 1'b0;
        end
        chk({tag, " pin_oe R11"}, pin_oe, eo);
        chk({tag, " pin_out R4"}, pin_out, ee);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog R9 actual=%h expected=%h", 32'd1, 32'd0);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0042));
        idle(3);
        @(negedge clk) rst = 1'b0;
        idle(1);

        // R9 reset state
        check_all("reset R9");

        // R2 pin mapping: pin 0 -> bit 31, pin 31 -> bit 0
        set_pins(32'h0000_0001); settle_model();
        brd(12'h008, 3'd4, d); chk("pin0 level R2", d, 32'h8000_0000);
        brd(12'h00C, 3'd4, d); chk("pin0 event R2", d, 32'h8000_0000);
        set_pins(32'h8000_0001); settle_model();
        brd(12'h008, 3'd4, d); chk("pin31 level R2", d, 32'h8000_0001);

        // R7 clear one bit, other stays
        bwr(12'h00C, 3'd4, 32'h8000_0000); m_write(3, 32'h8000_0000);
        brd(12'h00C, 3'd4, d); chk("w1c R7", d, 32'h0000_0001);
        bwr(12'h00C, 3'd4, 32'h0); check_all("w0 keep R7");

        // R8 irq with mask
        bwr(12'h010, 3'd4, 32'h0000_0001); m_write(4, 32'h0000_0001);
        chk("irq high R8", {31'd0, irq}, 32'd1);
        bwr(12'h00C, 3'd4, 32'h0000_0001); m_write(3, 32'h0000_0001);
        chk("irq low R8", {31'd0, irq}, 32'd0);

        // R3 narrow accesses
        bwr(12'h000, 3'd2, 32'hFFFF_FFFF);
        bwr(12'h010, 3'd1, 32'hFFFF_FFFF);
        check_all("narrow wr R3");
        brd(12'h008, 3'd2, d); chk("narrow rd R3", d, 32'h0);

        // R1 unmapped and unaligned
        bwr(12'h018, 3'd4, 32'hFFFF_FFFF);
        bwr(12'h002, 3'd4, 32'hFFFF_FFFF);
        check_all("unmapped wr R1");
        brd(12'h018, 3'd4, d); chk("unmapped rd R1", d, 32'h0);
        brd(12'h009, 3'd4, d); chk("unaligned rd R1", d, 32'h0);

        // R4 outputs and ignored input bits
        bwr(12'h000, 3'd4, 32'hF000_0000); m_write(0, 32'hF000_0000);
        bwr(12'h008, 3'd4, 32'hA5A5_A5A5); m_write(2, 32'hA5A5_A5A5);
        idle(3); settle_model();
        check_all("output R4");
        chk("pin1 out R4", {31'd0, pin_out[1]}, 32'd0);
        chk("pin0 out R4", {31'd0, pin_out[0]}, 32'd1);

        // R11 open-drain
        bwr(12'h004, 3'd4, 32'hC000_0000); m_write(1, 32'hC000_0000);
        check_all("odrain R11");
        chk("pin0 released R11", {31'd0, pin_oe[0]}, 32'd0);
        chk("pin1 pulls low R11", {30'd0, pin_oe[1], pin_out[1]}, 32'd2);

        // R6 falling-only mode on pin 8 (bit 23)
        bwr(12'h014, 3'd4, 32'h0080_0000); m_write(5, 32'h0080_0000);
        set_pins(pins | 32'h0000_0100); settle_model();
        brd(12'h00C, 3'd4, d); chk("rise ignored R6", d & 32'h0080_0000, 32'h0);
        set_pins(pins & ~32'h0000_0100); settle_model();
        brd(12'h00C, 3'd4, d); chk("fall sets R6", d & 32'h0080_0000, 32'h0080_0000);
        // output pin toggling raises no event
        set_pins(pins ^ 32'h0000_000F); settle_model();
        check_all("output no event R6");

        // R10 event and clear collide on pin 8 falling
        set_pins(pins | 32'h0000_0100); settle_model();
        bwr(12'h00C, 3'd4, 32'hFFFF_FFFF); m_write(3, 32'hFFFF_FFFF);
        m_pins(pins & ~32'h0000_0100);
        @(negedge clk); pins = pins & ~32'h0000_0100;
        @(negedge clk);
        bwr(12'h00C, 3'd4, 32'h0080_0000);
        idle(2); settle_model();
        brd(12'h00C, 3'd4, d); chk("event wins R10", d, 32'h0080_0000);
        check_all("after collide R10");

        // random mix
        for (int s = 0; s < 300; s++) begin
            int op = $urandom % 6;
            int ri = $urandom % 6;
            logic [31:0] w = $urandom;
            case (op)
                0, 5: begin bwr(12'(ri * 4), 3'd4, w); m_write(ri, w); idle(3); end
                1: begin bwr(12'(ri * 4), (($urandom % 2) == 0) ? 3'd1 : 3'd2, w); idle(3); end
                2: begin bwr(12'h018 + 12'($urandom % 1000), 3'd4, w); idle(3); end
                default: set_pins(pins ^ ($urandom & $urandom));
            endcase
            settle_model();
            if (s % 10 == 0) check_all("random R5");
        end
        check_all("final R6");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule